// File: doc/BRIEF.md
# Flag-Setting Integer ALU with NZCV Status

This block is a 32-bit integer unit that adds, subtracts, compares and bit-tests two operands. It keeps a four-bit status register holding the Negative, Zero, Carry and Overflow flags. An opcode picks the operation. A set-flags input decides whether a plain add or subtract may update the status register. The compare, compare-negative, AND-test and XOR-test operations always update the status register and never request a register-file write.

The block has one cycle of latency. The operation presented in a cycle is captured at the next rising clock edge. From that edge the result register, the write strobe and the flags show the outcome. A later stage can read the flags to decide whether a conditional instruction runs. Reset is synchronous and active high.

Operations sort into classes. Add and subtract use one shared adder. Subtract feeds the inverted second operand plus a carry-in of one. Arithmetic classes may change all four flags. The logical tests change only N and Z. Each class either requests a write or does not.

Top module: `nzcv_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `result_o` = 0, `wr_en_o` = 0 and all four flags = 0.
- R2: When the status register is updated, N takes bit 31 of the computed value (for the AND-test and XOR-test, the value A&B or A^B).
- R3: When the status register is updated, Z is 1 exactly when all 32 bits of the computed value are zero.
- R4: Add (`op_i`=1) and compare-negative (`op_i`=4) compute A+B. C is the carry out of bit 31. V is set when A and B have the same sign bit and the sum's sign bit differs from it.
- R5: Subtract (`op_i`=2) and compare (`op_i`=3) compute A−B. C is 1 when A ≥ B as unsigned values. V is set when the sign bits of A and B differ and the difference's sign bit differs from A's.
- R6: Compare (3) and compare-negative (4) update all four flags whatever `set_flags_i` is. They hold `wr_en_o` low and leave `result_o` unchanged.
- R7: AND-test (`op_i`=5, A&B) and XOR-test (`op_i`=6, A^B) update only N and Z. C and V keep their values, `wr_en_o` stays low and `result_o` is unchanged.
- R8: Add and subtract always raise `wr_en_o` and load `result_o`. They update the flags only when `set_flags_i` is 1. Otherwise all four flags hold.
- R9: Opcodes 0 and 7 are idle: `wr_en_o` low, and `result_o` and the flags unchanged.
- R10: Outputs change only at the rising edge that follows the cycle in which the operation is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code (0 idle, 1 add, 2 sub, 3 cmp, 4 cmn, 5 and-test, 6 xor-test, 7 idle) |
| set_flags_i | input | 1 | Lets add and subtract update the flags |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Registered result of the last add or subtract |
| wr_en_o | output | 1 | Registered result-write strobe |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |

## Verification
The assertions check the per-class rules on every cycle. They cover the write-strobe rules for compares and tests, C and V holding through the logical tests, all flags freezing for add and subtract with set-flags low, idle opcodes changing nothing, N and Z tracking the loaded result, and the reset state. The exact values of C and V, and whether the adder is correct, can only be shown by the bench's scenarios. These sweep boundary operands around zero, the sign bit and all-ones through every opcode with set-flags both low and high, then add a pseudo-random stream. Each outcome is compared against wide signed and unsigned arithmetic done in the bench.

// File: rtl/nzcv_alu_pkg.sv
package nzcv_alu_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_CMP = 3'd3,
    OP_CMN = 3'd4,
    OP_TST = 3'd5,
    OP_TEQ = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_SUM = 2'd0,
    SRC_AND = 2'd1,
    SRC_XOR = 2'd2
  } res_src_e;

  typedef struct packed {
    logic     writes;    // produces a register write
    logic     upd_nz;    // class may touch N and Z
    logic     upd_cv;    // class may touch C and V
    logic     gated;     // flag update depends on set_flags_i
    logic     subtract;  // adder runs A + ~B + 1
    res_src_e src;
  } op_ctrl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic op_ctrl_t decode_op(input logic [2:0] op);
    op_ctrl_t c;
    c = '{writes: 1'b0, upd_nz: 1'b0, upd_cv: 1'b0, gated: 1'b0,
          subtract: 1'b0, src: SRC_SUM};
    case (alu_op_e'(op))
      OP_ADD: begin c.writes = 1'b1; c.upd_nz = 1'b1; c.upd_cv = 1'b1; c.gated = 1'b1; end
      OP_SUB: begin c.writes = 1'b1; c.upd_nz = 1'b1; c.upd_cv = 1'b1; c.gated = 1'b1;
                    c.subtract = 1'b1; end
      OP_CMP: begin c.upd_nz = 1'b1; c.upd_cv = 1'b1; c.subtract = 1'b1; end
      OP_CMN: begin c.upd_nz = 1'b1; c.upd_cv = 1'b1; end
      OP_TST: begin c.upd_nz = 1'b1; c.src = SRC_AND; end
      OP_TEQ: begin c.upd_nz = 1'b1; c.src = SRC_XOR; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu_datapath.sv
module alu_datapath #(
  parameter int W = 32
) (
  input  logic [W-1:0]                a_i,
  input  logic [W-1:0]                b_i,
  input  logic                        subtract_i,
  input  nzcv_alu_pkg::res_src_e      src_i,
  output logic [W-1:0]                value_o,
  output logic                        carry_o,
  output logic                        ovf_o
);
  import nzcv_alu_pkg::*;

  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide_sum;
  logic [W-1:0] and_v;
  logic [W-1:0] xor_v;

  // Subtraction reuses the adder with the second operand inverted and carry-in 1.
  assign b_eff    = subtract_i ? ~b_i : b_i;
  assign wide_sum = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, subtract_i};

  // Bitwise results built per bit.
  for (genvar i = 0; i < W; i++) begin : g_bits
    assign and_v[i] = a_i[i] & b_i[i];
    assign xor_v[i] = a_i[i] ^ b_i[i];
  end

  always_comb begin
    unique case (src_i)
      SRC_AND: value_o = and_v;
      SRC_XOR: value_o = xor_v;
      default: value_o = wide_sum[W-1:0];
    endcase
  end

  // Carry out doubles as not-borrow in subtract mode.
  assign carry_o = wide_sum[W];
  // Same-sign inputs to the adder with a sign change at its output.
  assign ovf_o   = (a_i[MSB] == b_eff[MSB]) && (wide_sum[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu_flag_next.sv
module alu_flag_next #(
  parameter int W = 32
) (
  input  nzcv_alu_pkg::op_ctrl_t ctrl_i,
  input  logic                   set_flags_i,
  input  logic [W-1:0]           value_i,
  input  logic                   carry_i,
  input  logic                   ovf_i,
  input  nzcv_alu_pkg::nzcv_t    cur_i,
  output nzcv_alu_pkg::nzcv_t    next_o,
  output logic                   res_we_o
);
  import nzcv_alu_pkg::*;

  logic live;
  logic take_nz;
  logic take_cv;

  assign live    = ctrl_i.gated ? set_flags_i : 1'b1;
  assign take_nz = ctrl_i.upd_nz & live;
  assign take_cv = ctrl_i.upd_cv & live;

  always_comb begin
    next_o   = cur_i;
    if (take_nz) begin
      next_o.n = value_i[W-1];
      next_o.z = ~|value_i;
    end
    if (take_cv) begin
      next_o.c = carry_i;
      next_o.v = ovf_i;
    end
  end

  assign res_we_o = ctrl_i.writes;

endmodule

// File: rtl/alu_out_reg.sv
module alu_out_reg #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                res_we_i,
  input  logic [W-1:0]        value_i,
  input  nzcv_alu_pkg::nzcv_t flags_d_i,
  output logic [W-1:0]        result_q_o,
  output logic                wr_q_o,
  output nzcv_alu_pkg::nzcv_t flags_q_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q_o <= '0;
      wr_q_o     <= 1'b0;
      flags_q_o  <= '0;
    end else begin
      wr_q_o    <= res_we_i;
      flags_q_o <= flags_d_i;
      if (res_we_i) result_q_o <= value_i;
    end
  end

endmodule

// File: rtl/nzcv_alu.sv
module nzcv_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op_i,
  input  logic         set_flags_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic         flag_n_o,
  output logic         flag_z_o,
  output logic         flag_c_o,
  output logic         flag_v_o
);
  import nzcv_alu_pkg::*;

  op_ctrl_t     ctrl;
  logic [W-1:0] value;
  logic         carry;
  logic         ovf;
  nzcv_t        flags_q;
  nzcv_t        flags_d;
  logic         res_we;

  assign ctrl = decode_op(op_i);

  alu_datapath #(.W(W)) u_dp (
    .a_i        (a_i),
    .b_i        (b_i),
    .subtract_i (ctrl.subtract),
    .src_i      (ctrl.src),
    .value_o    (value),
    .carry_o    (carry),
    .ovf_o      (ovf)
  );

  alu_flag_next #(.W(W)) u_fn (
    .ctrl_i      (ctrl),
    .set_flags_i (set_flags_i),
    .value_i     (value),
    .carry_i     (carry),
    .ovf_i       (ovf),
    .cur_i       (flags_q),
    .next_o      (flags_d),
    .res_we_o    (res_we)
  );

  alu_out_reg #(.W(W)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .res_we_i   (res_we),
    .value_i    (value),
    .flags_d_i  (flags_d),
    .result_q_o (result_o),
    .wr_q_o     (wr_en_o),
    .flags_q_o  (flags_q)
  );

  assign flag_n_o = flags_q.n;
  assign flag_z_o = flags_q.z;
  assign flag_c_o = flags_q.c;
  assign flag_v_o = flags_q.v;

endmodule

// File: rtl/nzcv_alu_chk.sv
module nzcv_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op_i,
  input logic         set_flags_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic         flag_n_o,
  input logic         flag_z_o,
  input logic         flag_c_o,
  input logic         flag_v_o
);

  logic       prev_live = 1'b0;
  logic [3:0] flags;

  always_ff @(posedge clk) prev_live <= !rst;
  assign flags = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!wr_en_o && flags == 4'b0 && result_o == '0));

  assert_nz_track_R2: assert property (@(posedge clk) disable iff (rst)
    (prev_live && $past(op_i == 3'd1 || op_i == 3'd2) && $past(set_flags_i))
      |-> (flag_n_o == result_o[W-1] && flag_z_o == (result_o == '0)));

  assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (prev_live && $past(op_i == 3'd3 || op_i == 3'd4))
      |-> (!wr_en_o && $stable(result_o)));

  assert_test_cv_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (prev_live && $past(op_i == 3'd5 || op_i == 3'd6))
      |-> ($stable(flag_c_o) && $stable(flag_v_o) && !wr_en_o));

  assert_quiet_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (prev_live && $past(op_i == 3'd1 || op_i == 3'd2) && !$past(set_flags_i))
      |-> (wr_en_o && $stable(flags)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (prev_live && $past(op_i == 3'd0 || op_i == 3'd7))
      |-> (!wr_en_o && $stable(flags) && $stable(result_o)));

endmodule

bind nzcv_alu nzcv_alu_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_i        (op_i),
  .set_flags_i (set_flags_i),
  .result_o    (result_o),
  .wr_en_o     (wr_en_o),
  .flag_n_o    (flag_n_o),
  .flag_z_o    (flag_z_o),
  .flag_c_o    (flag_c_o),
  .flag_v_o    (flag_v_o)
);

// File: tb/tb_nzcv_alu.sv
`timescale 1ns/100ps
module tb_nzcv_alu;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   op_i = 3'd0;
  logic         set_flags_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] result_o;
  logic         wr_en_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  logic [W-1:0] e_res = '0;
  logic         e_wr = 1'b0;
  logic [3:0]   e_fl = 4'b0;

  always #2.5 clk = ~clk;

  nzcv_alu #(.W(W)) dut (.*);

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1: return "R2 R3 R4 R8";
      3'd2: return "R2 R3 R5 R8";
      3'd3: return "R2 R3 R5 R6";
      3'd4: return "R2 R3 R4 R6";
      3'd5, 3'd6: return "R2 R3 R7";
      default: return "R9";
    endcase
  endfunction

  task automatic compare(input string tag);
    vectors++;
    if (result_o !== e_res || wr_en_o !== e_wr ||
        {flag_n_o, flag_z_o, flag_c_o, flag_v_o} !== e_fl) begin
      fails++;
      $display("FAIL %s: got res=%h wr=%b nzcv=%b, expected res=%h wr=%b nzcv=%b",
               tag, result_o, wr_en_o, {flag_n_o, flag_z_o, flag_c_o, flag_v_o},
               e_res, e_wr, e_fl);
    end
  endtask

  // Drive at a falling edge; the rising edge captures; check at the next falling edge.
  task automatic apply(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic s);
    longint sa, sb, sr;
    logic [W:0] u;
    logic [W-1:0] v;
    bit upd;
    op_i = op; a_i = a; b_i = b; set_flags_i = s;
    #1;
    compare("R10");  // nothing moves before the edge
    sa = longint'($signed(a)); sb = longint'($signed(b));
    e_wr = (op == 3'd1 || op == 3'd2);
    upd = (op == 3'd3 || op == 3'd4 || op == 3'd5 || op == 3'd6) ||
          ((op == 3'd1 || op == 3'd2) && s);
    case (op)
      3'd1, 3'd4: begin
        u = {1'b0, a} + {1'b0, b}; v = u[W-1:0]; sr = sa + sb;
        if (upd) e_fl = {v[W-1], v == 0, u[W],
                         (sr > 64'sd2147483647 || sr < -64'sd2147483648)};
      end
      3'd2, 3'd3: begin
        v = a - b; sr = sa - sb;
        if (upd) e_fl = {v[W-1], v == 0, a >= b,
                         (sr > 64'sd2147483647 || sr < -64'sd2147483648)};
      end
      3'd5: begin v = a & b; e_fl[3:2] = {v[W-1], v == 0}; end
      3'd6: begin v = a ^ b; e_fl[3:2] = {v[W-1], v == 0}; end
      default: v = e_res;
    endcase
    if (e_wr) e_res = v;
    @(negedge clk);
    compare(tag_of(op));
  endtask

  logic [W-1:0] corners [8];

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'h8000_0001; corners[5] = 32'hFFFF_FFFF;
    corners[6] = 32'h5555_5555; corners[7] = 32'hAAAA_AAAA;
    // Dirty the inputs during reset; outputs must still come up cleared (R1).
    op_i = 3'd1; set_flags_i = 1'b1; a_i = '1; b_i = '1;
    repeat (3) @(negedge clk);
    compare("R1");
    rst = 1'b0; op_i = 3'd0;
    @(negedge clk);
    compare("R1");
    for (int s = 0; s < 2; s++)
      for (int op = 0; op < 8; op++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            apply(3'(op), corners[i], corners[j], 1'(s));
    begin
      logic [W-1:0] lf;
      lf = 32'hACE1_2345;
      for (int k = 0; k < 3000; k++) begin
        lf = {lf[W-2:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        apply(lf[2:0], lf ^ {lf[15:0], lf[31:16]}, {lf[7:0], lf[31:8]}, lf[5]);
      end
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      fails++; vectors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule